// File: doc/BRIEF.md
# Flow-Through Burst SRAM Array Model

This block is a synthesizable behavioural model of a flow-through synchronous SRAM. It has 32-bit words, four byte lanes and a parameterised address width. On every rising clock edge it decodes three chip selects, a load/advance control, a read/write select, per-lane write enables and a clock hold. From these it starts or continues a burst, or deselects. Read data flows through combinationally from the address held since the last edge. Write data is taken one edge after its command, so reads and writes can alternate on consecutive cycles with no idle cycle between them.

A load cycle with all chip selects active fixes the burst direction and the start address. Each following advance cycle steps the two low address bits in linear order and keeps the upper bits. The two low bits wrap, so every fourth step returns to the loaded address. The data output is tri-state style: `rdata` carries a value, and `rdata_drive` says whether the bus would be driven.

Top module: `burst_sram_model`

## Requirements
- R1: After a clock edge with `rst_n` low, `rdata_drive` is 0. An advance cycle issued right after reset leaves the bus undriven.
- R2: A load cycle (`advance`=0) with `ce0_n`=0, `ce1`=1 and `ce2_n`=0 and `read_sel`=1 makes `rdata` equal the stored word at `addr` after that edge. `rdata_drive` is 1 while `out_en_n` is 0.
- R3: A load cycle with `ce0_n`=1, `ce1`=0 or `ce2_n`=1 deselects the model, and `rdata_drive` becomes 0. Advance cycles after a deselect stay deselected.
- R4: In a write cycle, a 0 on `lane_we_n[i]` writes bits [8i+7:8i] of the word. The data for those bits comes from `wdata` at the next unstalled clock edge. Lanes whose enable is 1 keep their old contents.
- R5: A write cycle with `lane_we_n`=4'b1111 (write abort) leaves the array unchanged.
- R6: An advance cycle (`advance`=1) during a burst adds 1 modulo 4 to address bits [1:0] and keeps the upper bits. The fourth advance returns to the loaded address. The burst keeps the direction set at its load, and the advance cycle ignores `read_sel`, the chip selects and `addr`.
- R7: During a read burst, `out_en_n`=1 gives a dummy read: `rdata_drive` is 0.
- R8: During a write burst `rdata_drive` is 0, even with `out_en_n`=0. A read load on the edge right after a write command returns the data that edge wrote.
- R9: With `clk_hold`=1 an edge is ignored. No write takes place, the address does not advance, and `rdata_drive` and `rdata` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_hold | input | 1 | 1 inserts a wait state (edge ignored) |
| advance | input | 1 | 0 loads a new address and command, 1 continues the burst |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| read_sel | input | 1 | On load: 1 read burst, 0 write burst |
| lane_we_n | input | LANES | Per-byte write enables, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address for load cycles |
| wdata | input | LANES*LANE_W | Write data, sampled one edge after the command |
| rdata | output | LANES*LANE_W | Flow-through read data, 0 when not driven |
| rdata_drive | output | 1 | 1 when the data bus is driven |

## Verification
The bench starts a write burst at an address whose low bits are 2'b10, so the counter wraps inside the burst. It reads the burst back across the wrap. A counter that carried into the upper bits, or that never wrapped, would return the wrong words. A wait state is placed in the middle of a write burst with a poison value on `wdata`. A model that wrote during the hold, or advanced its address, would leave that value, or shifted data, in the array. Partial-lane writes, aborts and advance cycles with junk controls are also checked. Each exposes a model that writes masked lanes, writes on an abort, or decodes `read_sel` on continuation cycles. A read issued right after a write catches a one-edge slip in when write data is sampled.

// File: rtl/burst_sram_model.sv
module burst_sram_model #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_hold,
  input  logic                      advance,
  input  logic                      ce0_n,
  input  logic                      ce1,
  input  logic                      ce2_n,
  input  logic                      read_sel,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic                      out_en_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_drive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              burst_on, burst_rd;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lanes;

  wire step     = !clk_hold;
  wire selected = !ce0_n && ce1 && !ce2_n;
  wire cmd_wr   = advance ? (burst_on && !burst_rd) : (selected && !read_sel);

  assign nxt_addr = advance ? {addr_q[ADDR_W-1:2], addr_q[1:0] + 2'd1} : addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      burst_rd <= 1'b0;
      addr_q   <= '0;
      wr_pend  <= 1'b0;
      wr_addr  <= '0;
      wr_lanes <= '0;
    end else if (step) begin
      if (!advance) begin
        burst_on <= selected;
        burst_rd <= read_sel;
      end
      if (!advance || burst_on) addr_q <= nxt_addr;
      wr_pend  <= cmd_wr;
      wr_addr  <= nxt_addr;
      wr_lanes <= ~lane_we_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && step && wr_pend)
      for (int i = 0; i < LANES; i++)
        if (wr_lanes[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign rdata_drive = burst_on && burst_rd && !out_en_n;
  assign rdata       = rdata_drive ? mem[addr_q] : '0;
endmodule

module burst_sram_model_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_hold,
  input logic              advance,
  input logic              ce0_n,
  input logic              ce1,
  input logic              ce2_n,
  input logic              read_sel,
  input logic              rdata_drive,
  input logic              burst_on,
  input logic [ADDR_W-1:0] addr_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !rdata_drive);

  a_r3_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !advance && !(!ce0_n && ce1 && !ce2_n)) |=> !rdata_drive);

  a_r8_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !advance && !ce0_n && ce1 && !ce2_n && !read_sel) |=> !rdata_drive);

  a_r6_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && advance && burst_on) |=>
      (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) && (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |=> $stable(addr_q) && $stable(burst_on));
endmodule

bind burst_sram_model burst_sram_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .advance(advance),
  .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .read_sel(read_sel),
  .rdata_drive(rdata_drive), .burst_on(burst_on), .addr_q(addr_q)
);

// File: tb/burst_sram_model_tb.sv
module burst_sram_model_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 31;

  typedef struct packed {
    logic hold, adv, ce0n, ce1, ce2n, rs;
    logic [3:0] wen;
    logic oen;
    logic [5:0] a;
    logic [31:0] wd;
    logic edrv;
    logic [31:0] ed;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(logic hold, logic adv, logic ce0n, logic ce1, logic ce2n, logic rs,
                              logic [3:0] wen, logic oen, logic [5:0] a, logic [31:0] wd,
                              logic edrv, logic [31:0] ed, logic [3:0] req);
    return '{hold, adv, ce0n, ce1, ce2n, rs, wen, oen, a, wd, edrv, ed, req};
  endfunction

  localparam vec_t TBL [NV] = '{
    mk(0,0,0,1,0,0,4'h0,0,6'h20,32'h0,       0,32'h0,8),        // R8 write load, oe low
    mk(0,0,0,1,0,0,4'h0,0,6'h21,32'h01234567,0,32'h0,8),        // R8
    mk(0,0,0,1,0,0,4'h5,0,6'h20,32'h89ABCDEF,0,32'h0,4),        // R4 lanes 1,3 only
    mk(0,0,0,1,0,0,4'hF,0,6'h21,32'hAABBCCDD,0,32'h0,5),        // R5 abort
    mk(0,0,0,1,0,1,4'hF,0,6'h20,32'hFFFFFFFF,1,32'hAA23CC67,4), // R4 merged lanes
    mk(0,0,0,1,0,1,4'hF,0,6'h21,32'h0,       1,32'h89ABCDEF,5), // R5 unchanged
    mk(0,0,0,1,0,1,4'hF,1,6'h21,32'h0,       0,32'h0,7),        // R7 dummy read
    mk(0,0,0,0,0,1,4'hF,0,6'h21,32'h0,       0,32'h0,3),        // R3 ce1 low
    mk(0,1,0,1,0,1,4'hF,0,6'h00,32'h0,       0,32'h0,3),        // R3 continue deselect
    mk(0,0,0,1,1,1,4'hF,0,6'h21,32'h0,       0,32'h0,3),        // R3 ce2_n high
    mk(0,0,1,1,0,1,4'hF,0,6'h21,32'h0,       0,32'h0,3),        // R3 ce0_n high
    mk(0,0,0,1,0,0,4'h0,0,6'h0E,32'h0,       0,32'h0,8),        // R8 burst at 0x0E
    mk(0,1,1,0,0,1,4'h0,0,6'h3F,32'h10101010,0,32'h0,6),        // R6 junk controls
    mk(0,1,1,0,0,1,4'h0,0,6'h3F,32'h20202020,0,32'h0,6),        // R6
    mk(1,1,0,1,0,0,4'h0,0,6'h00,32'hDEADBEEF,0,32'h0,9),        // R9 hold in write
    mk(0,1,0,1,0,0,4'h0,0,6'h00,32'h30303030,0,32'h0,6),        // R6
    mk(0,1,0,1,0,0,4'h0,0,6'h00,32'h40404040,0,32'h0,6),        // R6 wrap
    mk(0,0,0,1,0,1,4'hF,0,6'h0C,32'h50505050,1,32'h30303030,9), // R9 no poison write
    mk(0,1,1,0,1,0,4'hF,0,6'h00,32'h0,       1,32'h40404040,6), // R6 read 13
    mk(0,1,1,0,1,0,4'hF,0,6'h00,32'h0,       1,32'h50505050,6), // R6 read 14
    mk(0,1,1,0,1,0,4'hF,0,6'h00,32'h0,       1,32'h20202020,6), // R6 read 15
    mk(0,1,1,0,1,0,4'hF,0,6'h00,32'h0,       1,32'h30303030,6), // R6 wrap to 12
    mk(1,0,1,0,1,0,4'h0,0,6'h00,32'h0,       1,32'h30303030,9), // R9 hold in read
    mk(0,1,0,1,0,1,4'hF,1,6'h00,32'h0,       0,32'h0,7),        // R7
    mk(0,0,0,1,0,0,4'hE,0,6'h0D,32'h0,       0,32'h0,8),        // R8 read then write
    mk(0,0,0,1,0,1,4'hF,0,6'h0D,32'h000000AB,1,32'h404040AB,4), // R4 R8 read after write
    mk(1,1,0,1,0,1,4'hF,0,6'h00,32'h12345678,1,32'h404040AB,9), // R9
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       0,32'h0,8),        // R8
    mk(1,1,0,1,0,1,4'hF,0,6'h00,32'hBAD0BAD0,0,32'h0,9),        // R9 hold keeps high-Z
    mk(0,0,0,1,0,1,4'hF,0,6'h00,32'h77777777,1,32'h77777777,9), // R9 write after hold
    mk(0,0,0,1,0,1,4'hF,0,6'h21,32'h0,       1,32'h89ABCDEF,2)  // R2 read load
  };

  logic        clk = 0, rst_n = 0, clk_hold = 0, advance = 0;
  logic        ce0_n = 1, ce1 = 0, ce2_n = 1, read_sel = 0, out_en_n = 1;
  logic [3:0]  lane_we_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rdata_drive;
  int          n_cmp = 0, n_bad = 0;

  burst_sram_model u_dut (
    .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .advance(advance),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .read_sel(read_sel),
    .lane_we_n(lane_we_n), .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input int req, input logic edrv, input logic [31:0] ed);
    n_cmp++;
    if (rdata_drive !== edrv || (edrv && rdata !== ed)) begin
      n_bad++;
      $display("FAIL R%0d: drive=%0b data=%h expected drive=%0b data=%h",
               req, rdata_drive, rdata, edrv, ed);
    end
  endtask

  task automatic apply(input vec_t v);
    clk_hold = v.hold; advance = v.adv; ce0_n = v.ce0n; ce1 = v.ce1; ce2_n = v.ce2n;
    read_sel = v.rs; lane_we_n = v.wen; out_en_n = v.oen; addr = v.a; wdata = v.wd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 32'h0);                 // R1 reset state
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      check(int'(TBL[i].req), TBL[i].edrv, TBL[i].ed);
    end
    apply(mk(0,0,0,1,0,1,4'hF,0,6'h0C,32'h0,1,32'h30303030,2));   // R2
    @(negedge clk);
    check(2, 1'b1, 32'h30303030);
    rst_n = 0;                             // R1 reset during a read burst
    @(negedge clk);
    check(1, 1'b0, 32'h0);
    rst_n = 1;
    apply(mk(0,1,0,1,0,1,4'hF,0,6'h00,32'h0,0,32'h0,1));          // R1 advance after reset
    @(negedge clk);
    check(1, 1'b0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule